// File: doc/BRIEF.md
# AC-link Receive Frame Decoder

This block turns the serial input stream of an AC-link audio codec into parallel slot words. It samples the data line on the falling edge of the codec bit clock. It aligns to frames using the sync line that the local transmit side drives. Each frame starts with a 16-bit tag slot. Twelve 20-bit data slots follow the tag. The tag says whether the frame as a whole is meaningful and which data slots carry content.

Each data slot that its tag marks as valid goes to one of two places. Slots in a parameter-selected set (by default the two main stereo sample slots, 3 and 4) are pushed into a small receive FIFO. Every other slot goes into its own holding register, and a one-cycle update strobe marks each write. All logic, including the FIFO read port, runs on the falling edge of the bit clock.

Top module: `acrx_decoder`

## Requirements
- R1: `sdata_in` is sampled on every falling edge of `bclk`, most significant bit first. Each delivered word holds exactly the bits of its own slot: 16 for the tag, 20 for a data slot.
- R2: A frame begins with the sample taken one falling edge after the edge that first sees `sync_in` high after a low. Its layout is the tag (16 bits) followed by slots 1 to 12 (20 bits each), 256 bits in all.
- R3: After reset the decoder delivers nothing until it sees a rising edge on `sync_in`.
- R4: While aligned, the edge that samples bit 255 of a frame must also see a sync rise, or the decoder becomes unaligned until the next rise. Slot 12 of that frame is still delivered. A sync rise at any other bit position discards the slot in progress and realigns the frame on that rise.
- R5: When tag bit 15 (frame valid) is clear, no data slot of that frame reaches the FIFO or any slot register.
- R6: Data slot k (1 to 12) is accepted only when tag bits 15 and 15-k of the same frame are both set. An accepted slot outside the FIFO set is written to bits [20k-1:20(k-1)] of `slot_data`, and `slot_upd[k-1]` is high for exactly one cycle. That cycle starts at the falling edge that samples the slot's last bit. A register that is not written keeps its value.
- R7: Accepted slots in the FIFO set (default: slots 3 and 4, mask 12'h00C with bit k-1 for slot k) are pushed into an 8-entry, 20-bit FIFO in arrival order. These slots never appear on `slot_data` or `slot_upd`, which stay 0 for them. While the FIFO is not empty, `rd_data` shows the oldest entry, and `rd_en` removes it.
- R8: `rx_full` is high while 8 entries are held. A push into a full FIFO is dropped and leaves the stored entries unchanged.
- R9: `rx_overrun` goes high on a dropped push and stays high until `ovr_clr` is asserted. If a drop and a clear fall in the same cycle, the flag stays set.
- R10: Asserting `rd_en` while the FIFO is empty has no effect.
- R11: After reset the FIFO is empty and not full, `rx_overrun` is 0, every slot register reads 0 and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Codec bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Frame sync as driven by the local transmit side |
| sdata_in | input | 1 | Serial data from the codec |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 20 | Oldest FIFO entry (valid while not empty) |
| rx_empty | output | 1 | FIFO holds no entry |
| rx_full | output | 1 | FIFO holds 8 entries |
| rx_overrun | output | 1 | Sticky flag: a push was dropped |
| slot_data | output | 240 | Holding registers of slots 1 to 12, slot k at bits [20k-1:20(k-1)] |
| slot_upd | output | 12 | One-cycle write strobe, bit k-1 for slot k |

## Verification
Frames are sent with these tag patterns: all valid, a sparse selection of valid slots, and frame-valid clear. Comparing them shows whether gating uses the frame-valid bit and the correct per-slot bit, and whether unwritten registers keep their values. Streams with no sync, a frame followed by a missing sync, and a sync rise in the middle of slot 2 show whether alignment depends only on rising edges and resets correctly. Back-to-back frames feeding the FIFO without reads push ten words into eight places. This separates dropping from overwriting, shows whether the overrun flag is sticky, and checks that a pop on an empty FIFO leaves the pointers intact.

// File: rtl/acrx_pkg.sv
`timescale 1ns/1ps
package acrx_pkg;
  localparam int TAG_W  = 16;
  localparam int SLOT_W = 20;
  localparam int NSLOT  = 12;
  localparam int IDX_W  = $clog2(NSLOT + 1);
  localparam int BIT_W  = $clog2(SLOT_W);

  typedef logic [SLOT_W-1:0] slot_word_t;
endpackage

// File: rtl/acrx_framer.sv
`timescale 1ns/1ps
// Bit/slot counter and input shifter; marks the last bit of every slot.
module acrx_framer
  import acrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             sd_i,
  output logic             slot_end_o,
  output logic [IDX_W-1:0] slot_idx_o,
  output slot_word_t       word_o
);
  localparam logic [BIT_W-1:0] TAG_LAST  = BIT_W'(TAG_W - 1);
  localparam logic [BIT_W-1:0] SLOT_LAST = BIT_W'(SLOT_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NSLOT);

  logic              sync_d_q;
  logic              lock_q, lock_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BIT_W-1:0]  bis_q, bis_d;
  logic [SLOT_W-2:0] sh_q, sh_d;

  logic             sync_rise, last_bit, at_end, misalign;
  logic [BIT_W-1:0] len_m1;

  always_comb begin
    sync_rise = sync_i & ~sync_d_q;
    len_m1    = (idx_q == '0) ? TAG_LAST : SLOT_LAST;
    at_end    = lock_q && (bis_q == len_m1);
    last_bit  = lock_q && (idx_q == LAST_IDX) && (bis_q == SLOT_LAST);
    misalign  = sync_rise && lock_q && !last_bit;
  end

  always_comb begin
    lock_d = lock_q;
    idx_d  = idx_q;
    bis_d  = bis_q;
    sh_d   = {sh_q[SLOT_W-3:0], sd_i};
    if (sync_rise) begin
      lock_d = 1'b1;
      idx_d  = '0;
      bis_d  = '0;
    end else if (last_bit) begin
      lock_d = 1'b0;
      idx_d  = '0;
      bis_d  = '0;
    end else if (lock_q) begin
      if (at_end) begin
        idx_d = idx_q + 1'b1;
        bis_d = '0;
      end else begin
        bis_d = bis_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d_q <= 1'b0;
      lock_q   <= 1'b0;
      idx_q    <= '0;
      bis_q    <= '0;
      sh_q     <= '0;
    end else begin
      sync_d_q <= sync_i;
      lock_q   <= lock_d;
      idx_q    <= idx_d;
      bis_q    <= bis_d;
      sh_q     <= sh_d;
    end
  end

  assign slot_end_o = at_end && !misalign;
  assign slot_idx_o = idx_q;
  assign word_o     = {sh_q, sd_i};

  // R2: the in-slot counter never passes the length of the current slot
  p_slot_len_r2: assert property (@(negedge clk) disable iff (!rst_n)
    lock_q |-> (bis_q <= len_m1));

  // R3: a sync rise always starts a new frame at the tag's first bit
  p_rise_aligns_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (sync_i && !sync_d_q) |=> (lock_q && idx_q == '0 && bis_q == '0));

  // R4: a frame end without a sync rise leaves the decoder unaligned
  p_lost_sync_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (last_bit && !(sync_i && !sync_d_q)) |=> !lock_q);
endmodule

// File: rtl/acrx_router.sv
`timescale 1ns/1ps
// Holds the tag of the current frame and steers accepted slots.
module acrx_router
  import acrx_pkg::*;
#(
  parameter logic [NSLOT-1:0] FIFO_SLOTS = 12'h00C
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slot_end_i,
  input  logic [IDX_W-1:0]        slot_idx_i,
  input  slot_word_t              word_i,
  output logic                    push_o,
  output slot_word_t              push_data_o,
  output logic [NSLOT*SLOT_W-1:0] slot_data_o,
  output logic [NSLOT-1:0]        slot_upd_o
);
  // tag_q[NSLOT] = frame valid, tag_q[NSLOT-k] = slot k valid
  logic [NSLOT:0]   tag_q;
  logic             tag_en;
  logic [NSLOT-1:0] hit;
  logic             fifo_hit;
  logic             push_q;
  slot_word_t       push_data_q;

  always_comb begin
    tag_en = slot_end_i && (slot_idx_i == '0);
    hit    = '0;
    for (int k = 1; k <= NSLOT; k++) begin
      if (slot_end_i && slot_idx_i == IDX_W'(k) && tag_q[NSLOT] && tag_q[NSLOT-k])
        hit[k-1] = 1'b1;
    end
    fifo_hit = |(hit & FIFO_SLOTS);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q       <= '0;
      push_q      <= 1'b0;
      push_data_q <= '0;
    end else begin
      if (tag_en)   tag_q       <= word_i[TAG_W-1 -: NSLOT+1];
      push_q <= fifo_hit;
      if (fifo_hit) push_data_q <= word_i;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (FIFO_SLOTS[g]) begin : g_to_fifo
      assign slot_data_o[g*SLOT_W +: SLOT_W] = '0;
      assign slot_upd_o[g] = 1'b0;
    end else begin : g_to_reg
      slot_word_t val_q;
      logic       upd_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
          upd_q <= 1'b0;
        end else begin
          upd_q <= hit[g];
          if (hit[g]) val_q <= word_i;
        end
      end
      assign slot_data_o[g*SLOT_W +: SLOT_W] = val_q;
      assign slot_upd_o[g] = upd_q;
    end
  end

  assign push_o      = push_q;
  assign push_data_o = push_data_q;

  // R6: at most one slot register is written per cycle
  p_one_upd_r6: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(slot_upd_o));

  // R7: a FIFO push never coincides with a register strobe
  p_push_excl_r7: assert property (@(negedge clk) disable iff (!rst_n)
    push_o |-> (slot_upd_o == '0));
endmodule

// File: rtl/acrx_rx_fifo.sv
`timescale 1ns/1ps
// Receive FIFO: drop-on-full with a sticky overrun flag.
module acrx_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 20
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovr_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d, count;
  logic         ovr_q, ovr_d;
  logic         do_push, do_pop, drop;

  always_comb begin
    count   = wptr_q - rptr_q;
    empty_o = (count == '0);
    full_o  = (count == FULL_CNT);
    do_push = push_i && !full_o;
    do_pop  = pop_i && !empty_o;
    drop    = push_i && full_o;
    wptr_d  = do_push ? wptr_q + 1'b1 : wptr_q;
    rptr_d  = do_pop  ? rptr_q + 1'b1 : rptr_q;
    if (drop)           ovr_d = 1'b1;
    else if (ovr_clr_i) ovr_d = 1'b0;
    else                ovr_d = ovr_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(negedge clk) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= push_data_i;
  end

  assign rd_data_o = mem[rptr_q[AW-1:0]];
  assign ovr_o     = ovr_q;

  // R8: occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(negedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8: a push into a full FIFO without a pop leaves occupancy unchanged
  p_drop_keeps_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> full_o);

  // R9: the overrun flag holds until cleared
  p_ovr_sticky_r9: assert property (@(negedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  // R10: popping an empty FIFO without a push keeps it empty
  p_pop_empty_r10: assert property (@(negedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/acrx_decoder.sv
`timescale 1ns/1ps
module acrx_decoder
  import acrx_pkg::*;
#(
  parameter int               FIFO_DEPTH = 8,
  parameter logic [NSLOT-1:0] FIFO_SLOTS = 12'h00C
)(
  input  logic                    bclk,
  input  logic                    rst_n,
  input  logic                    sync_in,
  input  logic                    sdata_in,
  input  logic                    rd_en,
  input  logic                    ovr_clr,
  output logic [SLOT_W-1:0]       rd_data,
  output logic                    rx_empty,
  output logic                    rx_full,
  output logic                    rx_overrun,
  output logic [NSLOT*SLOT_W-1:0] slot_data,
  output logic [NSLOT-1:0]        slot_upd
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             slot_end;
  logic [IDX_W-1:0] slot_idx;
  slot_word_t       word;
  logic             push;
  slot_word_t       push_data;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  acrx_framer u_framer (
    .clk        (bclk),
    .rst_n      (rst_core_n),
    .sync_i     (sync_in),
    .sd_i       (sdata_in),
    .slot_end_o (slot_end),
    .slot_idx_o (slot_idx),
    .word_o     (word)
  );

  acrx_router #(.FIFO_SLOTS(FIFO_SLOTS)) u_router (
    .clk         (bclk),
    .rst_n       (rst_core_n),
    .slot_end_i  (slot_end),
    .slot_idx_i  (slot_idx),
    .word_i      (word),
    .push_o      (push),
    .push_data_o (push_data),
    .slot_data_o (slot_data),
    .slot_upd_o  (slot_upd)
  );

  acrx_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) u_fifo (
    .clk         (bclk),
    .rst_n       (rst_core_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (rd_en),
    .ovr_clr_i   (ovr_clr),
    .rd_data_o   (rd_data),
    .empty_o     (rx_empty),
    .full_o      (rx_full),
    .ovr_o       (rx_overrun)
  );
endmodule

// File: tb/acrx_decoder_bench.sv
`timescale 1ns/1ps
module acrx_decoder_bench;
  localparam logic [11:0] FSET = 12'h00C;

  logic          bclk = 1'b0;
  logic          rst_n, sync_in, sdata_in, rd_en, ovr_clr;
  logic [19:0]   rd_data;
  logic          rx_empty, rx_full, rx_overrun;
  logic [239:0]  slot_data;
  logic [11:0]   slot_upd;

  int checks = 0;
  int fails  = 0;
  int upd_total [12];
  logic [19:0] m_slot [1:12];
  int          m_cnt  [1:12];
  logic [19:0] mq [$];
  logic        m_ovr;

  always #10 bclk = ~bclk;

  acrx_decoder u_acrx_decoder (
    .bclk(bclk), .rst_n(rst_n), .sync_in(sync_in), .sdata_in(sdata_in),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_data(rd_data), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_overrun(rx_overrun), .slot_data(slot_data),
    .slot_upd(slot_upd)
  );

  initial for (int k = 0; k < 12; k++) upd_total[k] = 0;
  always @(posedge bclk) begin
    for (int k = 0; k < 12; k++) if (slot_upd[k] === 1'b1) upd_total[k]++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] slotval(input logic [19:0] seed, input int k);
    return seed ^ 20'(k * 20'h11111);
  endfunction

  function automatic logic [255:0] build(input logic [15:0] tag, input logic [19:0] seed);
    logic [255:0] f;
    f = 256'(tag);
    for (int k = 1; k <= 12; k++) f = {f[235:0], slotval(seed, k)};
    return f;
  endfunction

  // expectation: only slots complete in the first ndone are delivered
  task automatic apply_model(input logic [15:0] tag, input logic [19:0] seed, input int ndone);
    for (int k = 1; k <= ndone; k++) begin
      if (tag[15] && tag[15-k]) begin
        if (FSET[k-1]) begin
          if (mq.size() < 8) mq.push_back(slotval(seed, k));
          else m_ovr = 1'b1;
        end else begin
          m_slot[k] = slotval(seed, k);
          m_cnt[k]++;
        end
      end
    end
  endtask

  task automatic drive_bit(input logic s, input logic d);
    @(posedge bclk);
    sync_in  = s;
    sdata_in = d;
  endtask

  task automatic send_bits(input logic [255:0] f, input int n, input bit en);
    for (int i = 0; i < n; i++) drive_bit(en && (i < 15), f[255-i]);
  endtask

  task automatic send_frame(input logic [255:0] f, input bit en, input bit next);
    send_bits(f, 255, en);
    drive_bit(en && next, f[0]);
  endtask

  task automatic lead_in();
    drive_bit(1'b0, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0, 1'b0);
  endtask

  task automatic check_state(input string req);
    for (int k = 1; k <= 12; k++) begin
      if (FSET[k-1]) begin
        chk(slot_data[k*20-1 -: 20] == 20'h0 && upd_total[k-1] == 0,
            {req, " R7 fifo slot silent"}, 64'(slot_data[k*20-1 -: 20]), 64'h0);
      end else begin
        chk(slot_data[k*20-1 -: 20] == m_slot[k], {req, " slot value"},
            64'(slot_data[k*20-1 -: 20]), 64'(m_slot[k]));
        chk(upd_total[k-1] == m_cnt[k], {req, " R6 strobe count"},
            64'(upd_total[k-1]), 64'(m_cnt[k]));
      end
    end
    chk(rx_empty == (mq.size() == 0), {req, " R7 empty"}, 64'(rx_empty), 64'(mq.size() == 0));
    chk(rx_full == (mq.size() == 8), {req, " R8 full"}, 64'(rx_full), 64'(mq.size() == 8));
    chk(rx_overrun == m_ovr, {req, " R9 overrun"}, 64'(rx_overrun), 64'(m_ovr));
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) begin
      logic [19:0] e;
      e = mq.pop_front();
      @(posedge bclk);
      chk(!rx_empty && rd_data == e, {req, " R7 fifo order"}, 64'(rd_data), 64'(e));
      rd_en = 1'b1;
      @(posedge bclk);
      rd_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(slot_data == '0 && slot_upd == '0, "R11 regs", 64'(slot_data[63:0]), 64'h0);
    chk(rx_empty && !rx_full && !rx_overrun, "R11 fifo flags",
        64'({rx_empty, rx_full, rx_overrun}), 64'b100);
  endtask

  task automatic t_no_sync();   // R3: nothing delivered before the first sync rise
    send_frame(build(16'hFFF8, 20'h13579), 1'b0, 1'b0);
    idle(3);
    check_state("R3");
  endtask

  task automatic t_full_frame();  // R1 R2 R6 R7: all slots valid
    lead_in();
    send_frame(build(16'hFFF8, 20'hA5C3E), 1'b1, 1'b0);
    apply_model(16'hFFF8, 20'hA5C3E, 12);
    idle(3);
    check_state("R1 R2");
    drain("R7");
    // R4: after a missing sync, a whole frame without a rise is ignored
    send_frame(build(16'hFFF8, 20'h0F0F0), 1'b0, 1'b0);
    idle(3);
    check_state("R4 unaligned");
  endtask

  task automatic t_sparse();  // R6: slots 1, 5, 6 valid only
    lead_in();
    send_frame(build(16'hC600, 20'h6B2D1), 1'b1, 1'b0);
    apply_model(16'hC600, 20'h6B2D1, 12);
    idle(3);
    check_state("R6 sparse");
  endtask

  task automatic t_frame_invalid();  // R5: frame-valid bit clear
    lead_in();
    send_frame(build(16'h7FF8, 20'h3C3C3), 1'b1, 1'b0);
    idle(3);
    check_state("R5");
  endtask

  task automatic t_realign();  // R4: sync rise in the middle of slot 2
    lead_in();
    send_bits(build(16'hFFF8, 20'h22222), 40, 1'b1);
    apply_model(16'hFFF8, 20'h22222, 1);
    drive_bit(1'b1, 1'b0);
    send_frame(build(16'hFFF8, 20'h5A5A5), 1'b1, 1'b0);
    apply_model(16'hFFF8, 20'h5A5A5, 12);
    idle(3);
    check_state("R4 realign");
    drain("R4");
  endtask

  task automatic t_overrun();  // R8 R9 R10
    lead_in();
    for (int f = 0; f < 5; f++) begin
      send_frame(build(16'h9800, 20'(20'h10000 + f * 20'h00101)), 1'b1, f != 4);
      apply_model(16'h9800, 20'(20'h10000 + f * 20'h00101), 12);
    end
    idle(3);
    check_state("R8 R9 overflow");
    drain("R8");
    @(posedge bclk);
    chk(rx_overrun == 1'b1, "R9 sticky after drain", 64'(rx_overrun), 64'h1);
    ovr_clr = 1'b1;
    @(posedge bclk);
    ovr_clr = 1'b0;
    m_ovr = 1'b0;
    @(posedge bclk);
    chk(rx_overrun == 1'b0, "R9 cleared", 64'(rx_overrun), 64'h0);
    rd_en = 1'b1;
    repeat (2) @(posedge bclk);
    rd_en = 1'b0;
    chk(rx_empty == 1'b1, "R10 pop empty", 64'(rx_empty), 64'h1);
    lead_in();
    send_frame(build(16'h9800, 20'h7E7E7), 1'b1, 1'b0);
    apply_model(16'h9800, 20'h7E7E7, 12);
    idle(3);
    check_state("R10 after empty pop");
    drain("R10");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; sdata_in = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    m_ovr = 1'b0;
    for (int k = 1; k <= 12; k++) begin m_slot[k] = '0; m_cnt[k] = 0; end
    repeat (3) @(posedge bclk);
    rst_n = 1'b1;
    repeat (4) @(posedge bclk);
    t_reset();
    t_no_sync();
    t_full_frame();
    t_sparse();
    t_frame_invalid();
    t_realign();
    t_overrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule